// File: doc/BRIEF.md
# Shared 64-bit Free-Running Timer with Compare Event

This block holds a 64-bit counter that only ever moves upward while it runs. Several cores can read it as a common time base over a simple 32-bit register bus. An 8-bit prescaler divides the input clock, so the count advances once every (prescale + 1) clocks. A 64-bit compare value is checked against the count on every clock. When the two are equal and compare is enabled, a sticky event flag is set. The interrupt output is that flag gated by an interrupt enable.

When the auto-advance option is on, each match adds a programmable 32-bit step to the compare value. A counter that never reloads can then produce a periodic event stream. Software reads the 64-bit count as two words, low word first. The low-word read captures the upper half into a shadow register, so the pair stays coherent even when the low half wraps between the two accesses.

Top module: `gtimer_cmp`

## Requirements
- R1: After reset, the count, the control word, the compare value, the step and the event flag all read 0, and `irq` is 0.
- R2: While control bit 0 (run) is 1, the count increases by one every (P+1) clocks, where P is control bits 15:8. Counting starts from prescale phase 0 on the first cycle that run is 1. The control word reads back as written in bits 3:0 and 15:8.
- R3: While run is 0, the count holds its value. The count low word (offset 0x00) and high word (offset 0x04) can be written only in this state.
- R4: While run is 1, writes to offsets 0x00 and 0x04 are ignored, so the count stays monotonic.
- R5: The low word is the count's bits 31:0 and the high word is its bits 63:32. A carry out of the low word increments the high word.
- R6: A read of offset 0x00 captures count bits 63:32 in the same cycle. Any later read of offset 0x04 returns that captured value and not the live high word.
- R7: If control bit 1 (compare enable) is 1 during a cycle in which the count equals the compare value, event flag bit 0 at offset 0x0C is 1 from the next cycle on. The compare value is at offsets 0x10 (low) and 0x14 (high). With bit 1 at 0, no match is recognised.
- R8: The event flag is sticky. A write to offset 0x0C with bit 0 set clears it, and a write with bit 0 at 0 leaves it unchanged.
- R9: `irq` is 1 exactly when the event flag is 1 and control bit 2 (interrupt enable) is 1.
- R10: With control bit 3 (auto-advance) set, every match adds the step register (offset 0x18) to the compare value in the same cycle that the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; a read of offset 0x00 updates the high-word shadow |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a low-word read taken just before the low half wraps, followed by a high-word read taken after it. The bench preloads the count a few ticks below the 32-bit boundary while the counter is stopped, then starts it. It reads the low word at a known cycle, lets the count pass the boundary, and only then reads the high word, which must still show the pre-wrap value. The auto-advance path is swept over every run length from 1 to 30 clocks, and the expected compare value is computed arithmetically in the bench.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
   // register byte offsets
   localparam int OFS_CNT_LO = 0;
   localparam int OFS_CNT_HI = 4;
   localparam int OFS_CTRL   = 8;
   localparam int OFS_STAT   = 12;
   localparam int OFS_CMP_LO = 16;
   localparam int OFS_CMP_HI = 20;
   localparam int OFS_STEP   = 24;
   // control bit positions
   localparam int CB_RUN  = 0;
   localparam int CB_CMP  = 1;
   localparam int CB_IRQ  = 2;
   localparam int CB_AUTO = 3;
   localparam int CB_PSC  = 8;
endpackage

// File: rtl/gtc_prescaler.sv
module gtc_prescaler #(
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PSC_W-1:0] psc,
   output logic             tick
);
   logic [PSC_W-1:0] phase_q;

   assign tick = run && (phase_q >= psc);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) phase_q <= '0;
      else if (tick)      phase_q <= '0;
      else                phase_q <= phase_q + 1'b1;
   end
endmodule

// File: rtl/gtc_counter.sv
module gtc_counter #(
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                tick,
   input  logic                wr_lo,
   input  logic                wr_hi,
   input  logic [DATA_W-1:0]   wdata,
   output logic [2*DATA_W-1:0] count
);
   localparam int CNT_W = 2 * DATA_W;

   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else if (!run && wr_lo) count[DATA_W-1:0]     <= wdata;
      else if (!run && wr_hi) count[CNT_W-1:DATA_W] <= wdata;
      else if (tick)          count <= count + 1'b1;
   end

   // R4
   cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run) |-> (count == $past(count) || count == $past(count) + 1'b1));

   // R3
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(run) && !$past(wr_lo) && !$past(wr_hi)) |-> $stable(count));
endmodule

// File: rtl/gtc_compare.sv
module gtc_compare #(
   parameter int DATA_W      = 32,
   parameter bit HAS_AUTOINC = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmp_en,
   input  logic                auto_en,
   input  logic [2*DATA_W-1:0] count,
   input  logic                wr_lo,
   input  logic                wr_hi,
   input  logic                wr_step,
   input  logic                clr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [2*DATA_W-1:0] cmp_q,
   output logic [DATA_W-1:0]   step_q,
   output logic                flag_q
);
   localparam int CNT_W = 2 * DATA_W;

   logic             match;
   logic [CNT_W-1:0] cmp_nxt;
   logic             adv;

   assign match = cmp_en && (count == cmp_q);

   generate
      if (HAS_AUTOINC) begin : g_auto
         always_ff @(posedge clk) begin
            if (!rst_n)       step_q <= '0;
            else if (wr_step) step_q <= wdata;
         end
         assign cmp_nxt = cmp_q + CNT_W'(step_q);
         assign adv     = match && auto_en;

         // R10
         step_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(match && auto_en && !wr_lo && !wr_hi)
               |-> cmp_q == $past(cmp_q) + CNT_W'($past(step_q)));
      end else begin : g_fixed
         assign step_q  = '0;
         assign cmp_nxt = cmp_q;
         assign adv     = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     cmp_q <= '0;
      else if (wr_lo) cmp_q[DATA_W-1:0]     <= wdata;
      else if (wr_hi) cmp_q[CNT_W-1:DATA_W] <= wdata;
      else if (adv)   cmp_q <= cmp_nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (match) flag_q <= 1'b1;
      else if (clr)   flag_q <= 1'b0;
   end

   // R8
   flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flag_q && !clr) |-> flag_q);

   // R7
   flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(cmp_en));
endmodule

// File: rtl/gtimer_cmp.sv
module gtimer_cmp #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5,
   parameter int PSC_W       = 8,
   parameter bit HAS_AUTOINC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   import gtc_pkg::*;

   localparam int CNT_W = 2 * DATA_W;

   generate
      if (CB_PSC + PSC_W > DATA_W) begin : g_bad_psc
         $error("prescaler field does not fit in the control word");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("address too narrow for the register map");
      end
   endgenerate

   logic             run_q, cmpen_q, irqen_q, auto_q;
   logic [PSC_W-1:0] psc_q;
   logic [DATA_W-1:0] shadow_q;
   logic [CNT_W-1:0] count, cmp_q;
   logic [DATA_W-1:0] step_q;
   logic             flag_q, tick;
   logic             sel_lo, sel_hi, sel_ctrl, sel_stat, sel_clo, sel_chi, sel_step;

   assign sel_lo   = bus_addr == ADDR_W'(OFS_CNT_LO);
   assign sel_hi   = bus_addr == ADDR_W'(OFS_CNT_HI);
   assign sel_ctrl = bus_addr == ADDR_W'(OFS_CTRL);
   assign sel_stat = bus_addr == ADDR_W'(OFS_STAT);
   assign sel_clo  = bus_addr == ADDR_W'(OFS_CMP_LO);
   assign sel_chi  = bus_addr == ADDR_W'(OFS_CMP_HI);
   assign sel_step = bus_addr == ADDR_W'(OFS_STEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         cmpen_q <= 1'b0;
         irqen_q <= 1'b0;
         auto_q  <= 1'b0;
         psc_q   <= '0;
      end else if (bus_wr && sel_ctrl) begin
         run_q   <= bus_wdata[CB_RUN];
         cmpen_q <= bus_wdata[CB_CMP];
         irqen_q <= bus_wdata[CB_IRQ];
         auto_q  <= bus_wdata[CB_AUTO];
         psc_q   <= bus_wdata[CB_PSC +: PSC_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                shadow_q <= '0;
      else if (bus_rd && sel_lo) shadow_q <= count[CNT_W-1:DATA_W];
   end

   gtc_prescaler #(.PSC_W(PSC_W)) psc_i (
      .clk(clk), .rst_n(rst_n), .run(run_q), .psc(psc_q), .tick(tick)
   );

   gtc_counter #(.DATA_W(DATA_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick),
      .wr_lo(bus_wr && sel_lo), .wr_hi(bus_wr && sel_hi),
      .wdata(bus_wdata), .count(count)
   );

   gtc_compare #(.DATA_W(DATA_W), .HAS_AUTOINC(HAS_AUTOINC)) cmp_i (
      .clk(clk), .rst_n(rst_n), .cmp_en(cmpen_q), .auto_en(auto_q),
      .count(count), .wr_lo(bus_wr && sel_clo), .wr_hi(bus_wr && sel_chi),
      .wr_step(bus_wr && sel_step), .clr(bus_wr && sel_stat && bus_wdata[0]),
      .wdata(bus_wdata), .cmp_q(cmp_q), .step_q(step_q), .flag_q(flag_q)
   );

   assign irq = flag_q && irqen_q;

   always_comb begin
      bus_rdata = '0;
      if (sel_lo)        bus_rdata = count[DATA_W-1:0];
      else if (sel_hi)   bus_rdata = shadow_q;
      else if (sel_ctrl) begin
         bus_rdata[CB_RUN]            = run_q;
         bus_rdata[CB_CMP]            = cmpen_q;
         bus_rdata[CB_IRQ]            = irqen_q;
         bus_rdata[CB_AUTO]           = auto_q;
         bus_rdata[CB_PSC +: PSC_W]   = psc_q;
      end
      else if (sel_stat) bus_rdata[0] = flag_q;
      else if (sel_clo)  bus_rdata = cmp_q[DATA_W-1:0];
      else if (sel_chi)  bus_rdata = cmp_q[CNT_W-1:DATA_W];
      else if (sel_step) bus_rdata = step_q;
   end

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irqen_q && flag_q));
endmodule

// File: tb/gtimer_cmp_tb.sv
module gtimer_cmp_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   gtimer_cmp dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called just after a falling edge; returns one falling edge later
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd64(output logic [63:0] v);
      logic [31:0] lo, hi;
      rd(5'h00, lo);
      rd(5'h04, hi);
      v = {hi, lo};
   endtask

   task automatic set_count(input logic [63:0] v);
      wr(5'h00, v[31:0]);
      wr(5'h04, v[63:32]);
   endtask

   initial begin
      #2_000_000;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [63:0] c64;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd64(c64);        chk("R1 count", c64, 64'd0);
      rd(5'h08, v);     chk("R1 ctrl", v, 0);
      rd(5'h0C, v);     chk("R1 flag", v, 0);
      rd(5'h10, v);     chk("R1 cmp", v, 0);
      rd(5'h18, v);     chk("R1 step", v, 0);
      chk("R1 irq", irq, 0);

      // R2 control readback
      wr(5'h08, 32'h0000_2A0E);
      rd(5'h08, v);     chk("R2 ctrl readback", v, 32'h0000_2A0E);
      wr(5'h08, 0);

      // R2 / R3 prescaler sweep: run for D edges, expect D/(P+1)
      for (int p = 0; p < 5; p++) begin
         for (int k = 0; k < 14; k += 3) begin
            set_count(64'd0);
            wr(5'h08, 32'(p) << 8 | 32'h1);
            repeat (k) @(negedge clk);
            wr(5'h08, 0);
            rd64(c64);
            chk("R2 prescaled count", c64, 64'((k + 1) / (p + 1)));
         end
      end
      repeat (6) @(negedge clk);
      rd64(c64);
      chk("R3 frozen while stopped", c64, 64'(13 / 5));

      // R4 writes ignored while running
      set_count(64'd0);
      wr(5'h08, 1);
      wr(5'h00, 32'h1234);
      wr(5'h04, 32'h5);
      wr(5'h08, 0);
      rd64(c64);        chk("R4 write ignored", c64, 64'd3);

      // R5 carry into high word
      set_count(64'h7_FFFF_FFFE);
      wr(5'h08, 1);
      repeat (3) @(negedge clk);
      wr(5'h08, 0);
      rd64(c64);        chk("R5 carry", c64, 64'h8_0000_0002);

      // R6 coherent pair across a low-word wrap
      set_count(64'h0_FFFF_FFF0);
      wr(5'h08, 1);
      repeat (4) @(negedge clk);
      rd(5'h00, v);     chk("R6 low before wrap", v, 32'hFFFF_FFF4);
      repeat (20) @(negedge clk);
      rd(5'h04, v);     chk("R6 shadow high", v, 0);
      wr(5'h08, 0);
      rd64(c64);        chk("R6 high after fresh low read", c64[63:32], 1);

      // R7 / R9 exact match timing
      set_count(64'd0);
      wr(5'h10, 10); wr(5'h14, 0); wr(5'h0C, 1);
      wr(5'h08, 32'h7);
      repeat (10) @(negedge clk);
      chk("R9 irq before match", irq, 0);
      @(negedge clk);
      chk("R7 irq after match", irq, 1);
      rd(5'h0C, v);     chk("R7 flag set", v, 1);
      // R8 clear behaviour
      wr(5'h0C, 0);
      rd(5'h0C, v);     chk("R8 write 0 keeps flag", v, 1);
      wr(5'h0C, 1);
      #1 chk("R8 irq cleared", irq, 0);
      rd(5'h0C, v);     chk("R8 flag cleared", v, 0);
      wr(5'h08, 0);

      // R9 interrupt enable gating
      set_count(64'd0);
      wr(5'h10, 3);
      wr(5'h08, 32'h3);
      repeat (10) @(negedge clk);
      wr(5'h08, 0);
      rd(5'h0C, v);     chk("R9 flag without enable", v, 1);
      chk("R9 irq masked", irq, 0);
      wr(5'h08, 32'h6);
      #1 chk("R9 irq once enabled", irq, 1);
      wr(5'h08, 0);

      // R7 compare disabled
      set_count(64'd0);
      wr(5'h0C, 1);
      wr(5'h08, 32'h5);
      repeat (10) @(negedge clk);
      wr(5'h08, 0);
      rd(5'h0C, v);     chk("R7 no match when disabled", v, 0);
      chk("R7 irq when disabled", irq, 0);

      // R10 auto-advance sweep
      wr(5'h18, 7);
      rd(5'h18, v);     chk("R10 step readback", v, 7);
      for (int d = 1; d <= 30; d++) begin
         int c;
         set_count(64'd0);
         wr(5'h10, 5); wr(5'h14, 0); wr(5'h0C, 1);
         wr(5'h08, 32'hB);
         repeat (d - 1) @(negedge clk);
         wr(5'h08, 0);
         c = 5;
         while (c < d) c += 7;
         rd(5'h10, v);  chk("R10 advanced compare", v, 32'(c));
         rd(5'h0C, v);  chk("R10 flag", v, (d > 5) ? 1 : 0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule